// File: doc/BRIEF.md
# Guarded Non-Maskable Interrupt Edge Detector

This block turns the asynchronous non-maskable interrupt pin into a single pending flag in the bus clock domain. The pin first passes through a synchronizer. Either its rising or its falling transition is then recognised, depending on a polarity bit held inside the block. A recognised transition sets a sticky pending flag. The flag stays set until the processor side pulses an acknowledge. While the flag is set, the block also presents the fixed top priority level of 16.

Software changes the polarity by writing a new select value with a one-cycle strobe. Flipping the polarity could make the current pin level look like a transition. To prevent this, every select write opens a blanking window. Detection is off in the write cycle and for a fixed number of bus clocks after it. This also happens when the written value equals the old one. The block keeps tracking the pin level during the window, so a level that is steady when the window closes is never reported as an edge. The same window is armed by reset. Acceptance gating against the processor's block bit and the exception entry are handled downstream.

Top module: `nmi_edge_guard`

## Requirements
- R1: After reset, `pend_o` is 0, `prio_o` is 0 and the polarity is rising. Detection is also suppressed for the first BLANK_CYCLES (6) clock cycles after reset.
- R2: A pin change that is stable before clock edge k appears on `pend_o` after edge k+2. The path is two synchronizer flops and the pending register.
- R3: With polarity 1 (rising), a 0-to-1 pin transition sets `pend_o`, and a 1-to-0 transition has no effect.
- R4: With polarity 0 (falling), a 1-to-0 pin transition sets `pend_o`, and a 0-to-1 transition has no effect.
- R5: Once set, `pend_o` stays 1 until a cycle with `ack_i` high. It reads 0 after that clock edge, unless R6 applies.
- R6: When a transition is detected in the same cycle as `ack_i`, `pend_o` stays 1.
- R7: A cycle with `sel_wr_i` high loads `sel_rise_i` as the new polarity. No transition is detected in that cycle or in the following 6 cycles. This holds even if the written value is unchanged.
- R8: When blanking ends, a pin level that has been steady is not reported. A transition that occurred during blanking is lost.
- R9: `prio_o` equals 16 whenever `pend_o` is 1, and equals 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous interrupt pin |
| sel_rise_i | input | 1 | Polarity value to write: 1 rising, 0 falling |
| sel_wr_i | input | 1 | One-cycle strobe that writes the polarity |
| ack_i | input | 1 | One-cycle acknowledge that clears the pending flag |
| pend_o | output | 1 | Sticky pending flag |
| prio_o | output | 5 | Presented priority level: 16 while pending, else 0 |

## Verification
The in-line assertions check, on every cycle, the relations that hold at any instant:
- the pending flag holds without an acknowledge;
- a falling flag always follows an acknowledge;
- a strobe always reloads the full window;
- the flag never rises from a cycle inside the blanking window;
- the presented level always tracks the flag.

The bench's cycle-by-cycle reference model covers the behaviour that depends on stimulus history:
- the exact three-edge latency;
- polarity selection and rejection of the opposite edge;
- an edge colliding with an acknowledge;
- transitions lost during a window, including one opened by rewriting the same value;
- a steady level at the end of a window not being reported.

// File: rtl/nmi_edge_guard.sv
module nmi_edge_guard #(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 6,
  parameter int LEVEL_W      = 5,
  parameter int NMI_LEVEL    = 16,
  parameter bit RESET_RISE   = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_i,
  input  logic               sel_rise_i,
  input  logic               sel_wr_i,
  input  logic               ack_i,
  output logic               pend_o,
  output logic [LEVEL_W-1:0] prio_o
);

  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(BLANK_CYCLES);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rise_q;
  logic [CW-1:0]          blank_q;
  logic                   pend_q;

  wire level   = sync_q[SYNC_STAGES-1];
  wire blanked = (blank_q != '0) || sel_wr_i;
  wire hit     = !blanked && (rise_q ? (level && !prev_q) : (!level && prev_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= RESET_RISE;
      blank_q <= CNT_LOAD;
    end else if (sel_wr_i) begin
      rise_q  <= sel_rise_i;
      blank_q <= CNT_LOAD;
    end else if (blank_q != '0) begin
      blank_q <= blank_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= hit || (pend_q && !ack_i);
  end

  assign pend_o = pend_q;
  assign prio_o = pend_q ? LEVEL_W'(NMI_LEVEL) : '0;

  a_r5_hold_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !ack_i) |=> pend_o);

  a_r5_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_o) |-> $past(ack_i));

  a_r7_window_reload: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_i |=> (blank_q == CNT_LOAD));

  a_r7_no_set_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_o) |-> ($past(blank_q) == '0 && !$past(sel_wr_i)));

  a_r9_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_o != '0) == pend_o);

endmodule

// File: tb/test_nmi_edge_guard.sv
module test_nmi_edge_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, sel_val = 1'b1, sel_wr = 1'b0, ack = 1'b0;
  logic pend;
  logic [4:0] prio;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  nmi_edge_guard i_nmi_edge_guard (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .sel_rise_i(sel_val),
    .sel_wr_i(sel_wr), .ack_i(ack), .pend_o(pend), .prio_o(prio)
  );

  bit q[$];
  bit m_pend, m_sel;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      q = {1'b0, 1'b0, 1'b0};
      m_pend = 0; m_sel = 1; m_cnt = 6;
    end else begin
      bit s2, pv, det;
      s2 = q[1]; pv = q[2];
      det = (m_cnt == 0) && !sel_wr && (m_sel ? (s2 && !pv) : (!s2 && pv));
      m_pend = det || (m_pend && !ack);
      if (sel_wr) begin m_sel = sel_val; m_cnt = 6; end
      else if (m_cnt > 0) m_cnt--;
      q.push_front(pin);
      void'(q.pop_back());
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cur_req, pend, m_pend);
      chk("R9", prio, m_pend ? 16 : 0);
    end
    if (cycles > 20000) begin
      chk("watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ack();
    ack = 1; step(1); ack = 0;
  endtask

  task automatic write_sel(bit v);
    sel_val = v; sel_wr = 1; step(1); sel_wr = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    chk("R1", pend, 0);
    chk("R1", prio, 0);
    cur_req = "R1";
    pin = 1; step(2); pin = 0; step(8);
    chk("R1", pend, 0);

    cur_req = "R2";
    pin = 1; step(2);
    chk("R2", pend, 0);
    step(1);
    chk("R2", pend, 1);
    chk("R9", prio, 16);

    cur_req = "R5";
    step(4);
    chk("R5", pend, 1);
    pulse_ack();
    chk("R5", pend, 0);

    cur_req = "R3";
    pin = 0; step(6);
    chk("R3", pend, 0);
    pin = 1; step(5);
    chk("R3", pend, 1);
    pulse_ack();

    cur_req = "R7";
    write_sel(0);
    pin = 0; step(2); pin = 1; step(3);
    chk("R7", pend, 0);

    cur_req = "R4";
    step(6);
    pin = 0; step(5);
    chk("R4", pend, 1);
    pulse_ack();
    pin = 1; step(6);
    chk("R4", pend, 0);

    cur_req = "R6";
    pin = 0; step(2);
    ack = 1; step(1); ack = 0;
    chk("R6", pend, 1);
    step(2);
    pulse_ack();
    chk("R6", pend, 0);

    cur_req = "R7";
    pin = 1; step(6);
    write_sel(0);
    pin = 0; step(8);
    chk("R7", pend, 0);

    cur_req = "R8";
    write_sel(1);
    pin = 1; step(10);
    chk("R8", pend, 0);
    write_sel(0);
    step(10);
    chk("R8", pend, 0);
    pin = 0; step(5);
    chk("R8", pend, 1);
    pulse_ack();

    cur_req = "R5";
    step(3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule